// File: doc/BRIEF.md
# Serial Statistics Read Slave

This block is the target end of a two-wire, host-clocked management link. A host toggles a serial clock and drives a data line; the block recognises a command frame and answers in one of two ways. A read frame names one of two tables (statistics counters or stored configuration words) and a 7-bit address. The block hands both to the local register file through a strobe and shifts the returned 32-bit word back to the host, most significant bit first. A clear frame asks the counter logic to zero either every counter of one port or one single counter. The block passes this on as a one-cycle strobe with a mode flag and a 7-bit selector.

The serial clock and data are brought into the block clock domain through a small synchronizer, and edges of the serial clock are detected there. Incoming bits are taken on rising serial edges. The data output and its enable change only after falling serial edges, so the host samples stable values on its next rising edge. The output enable stands for a tri-state driver and is high only while the 32 data bits are on the line.

Top module: `scr_slave`

## Requirements
- R1: After reset `ser_oe`, `rd_stb` and `clr_stb` are all low, and they stay low until a valid frame has been received.
- R2: A read frame consists of at least 32 ones, the start pattern 0 then 1, the read opcode 1 then 0, one table bit, and a 7-bit address sent MSB first. Such a frame gives exactly one `rd_stb` pulse, with `rd_tbl` and `rd_addr` equal to the received fields. The block then returns `rd_data` on `ser_do`, bit 31 first.
- R3: A frame preceded by only 31 ones, after a zero, is ignored: no strobe is raised and `ser_oe` stays low.
- R4: Preambles longer than 32 ones are accepted just like a preamble of exactly 32.
- R5: During the two serial cycles that follow the last address bit, `ser_oe` stays low. Data bit 31 is present when the host samples at the third rising edge after that bit.
- R6: `ser_oe` is high for exactly 32 host samples and is low at the sample that follows the last data bit.
- R7: The opcodes 0 then 0 and 1 then 1 abort the frame: no strobe and no output enable. The next valid frame is served normally.
- R8: A clear frame uses the opcode 0 then 1, followed by a mode bit and a 7-bit selector sent MSB first. It gives one `clr_stb` pulse, one block-clock cycle wide, with `clr_sel` equal to the selector. Mode 1 sets `clr_port_mode` high, meaning all counters of the selected port are cleared.
- R9: A clear frame with mode bit 0 sets `clr_port_mode` low, meaning only the single counter at the selected index is cleared.
- R10: If a 0 follows the start bit 0 in place of 1, the frame is abandoned and no strobe is raised.
- R11: `ser_do` and `ser_oe` change only after a falling serial edge. They keep their value during the high phase of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_di | input | 1 | Serial command data from the host |
| ser_do | output | 1 | Serial read data to the host |
| ser_oe | output | 1 | Output enable for the serial data driver |
| rd_stb | output | 1 | One-cycle read request to the register file |
| rd_tbl | output | 1 | Table select: 1 configuration words, 0 counters |
| rd_addr | output | ADDR_W | Register address of the read |
| rd_data | input | DATA_W | Word returned by the register file |
| clr_stb | output | 1 | One-cycle counter clear request |
| clr_port_mode | output | 1 | 1 clears all counters of a port, 0 clears one counter |
| clr_sel | output | ADDR_W | Port number or counter index to clear |

## Verification
The bench builds the block with its default values: a 32-bit word, a 7-bit address, a 32-one preamble and a two-stage synchronizer. With these values the 31-versus-32 preamble boundary, the full 128-entry address range of both tables, and all four opcode codes can be reached in a run of a few dozen frames. The serial half-period is eight block clocks, which leaves the synchronizer latency well inside each serial phase. This lets the bench check that the outputs hold still across each rising serial edge.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int SCR_ADDR_W = 7;
    localparam int SCR_DATA_W = 32;
    localparam int SCR_PRE_LEN = 32;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_CLEAR = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OP,
        ST_ARG,
        ST_TA,
        ST_DATA
    } scr_state_e;

    typedef enum logic [1:0] {
        CMD_BAD,
        CMD_READ,
        CMD_CLEAR
    } scr_cmd_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic dat;
    } scr_edge_t;

    function automatic scr_cmd_e decode_op(input logic [1:0] code);
        if (code == OPC_READ)       return CMD_READ;
        else if (code == OPC_CLEAR) return CMD_CLEAR;
        else                        return CMD_BAD;
    endfunction

endpackage

// File: rtl/scr_edge_sync.sv
module scr_edge_sync
    import scr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_clk,
    input  logic      ser_di,
    output scr_edge_t ev
);

    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic              ck_prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_q <= '0;
                    dt_q <= '0;
                end else begin
                    ck_q <= ser_clk;
                    dt_q <= ser_di;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_q <= '0;
                    dt_q <= '0;
                end else begin
                    ck_q <= {ck_q[STAGES-2:0], ser_clk};
                    dt_q <= {dt_q[STAGES-2:0], ser_di};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ck_prev_q <= 1'b0;
        else     ck_prev_q <= ck_q[STAGES-1];
    end

    always_comb begin
        ev.rise = ck_q[STAGES-1] & ~ck_prev_q;
        ev.fall = ~ck_q[STAGES-1] & ck_prev_q;
        ev.dat  = dt_q[STAGES-1];
    end

endmodule

// File: rtl/scr_frame_parser.sv
module scr_frame_parser
    import scr_pkg::*;
#(
    parameter int PRE_LEN = SCR_PRE_LEN,
    parameter int ADDR_W  = SCR_ADDR_W,
    parameter int DATA_W  = SCR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  scr_edge_t         ev,
    output logic              data_phase,
    output logic              rd_stb,
    output logic              rd_tbl,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              clr_stb,
    output logic              clr_port_mode,
    output logic [ADDR_W-1:0] clr_sel
);

    localparam int ARG_W  = ADDR_W + 1;
    localparam int ONES_W = $clog2(PRE_LEN + 1);
    localparam int CNT_W  = (DATA_W > ARG_W) ? $clog2(DATA_W) : $clog2(ARG_W + 1);
    localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(PRE_LEN);
    localparam logic [CNT_W-1:0]  ARG_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(DATA_W - 1);

    scr_state_e        state_q;
    logic [ONES_W-1:0] ones_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              op_msb_q;
    logic              is_read_q;
    logic [ARG_W-1:0]  arg_q;
    logic [ARG_W-1:0]  arg_next;

    assign arg_next   = {arg_q[ARG_W-2:0], ev.dat};
    assign data_phase = (state_q == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_HUNT;
            ones_q        <= '0;
            cnt_q         <= '0;
            op_msb_q      <= 1'b0;
            is_read_q     <= 1'b0;
            arg_q         <= '0;
            rd_stb        <= 1'b0;
            rd_tbl        <= 1'b0;
            rd_addr       <= '0;
            clr_stb       <= 1'b0;
            clr_port_mode <= 1'b0;
            clr_sel       <= '0;
        end else begin
            rd_stb  <= 1'b0;
            clr_stb <= 1'b0;
            if (ev.rise) begin
                unique case (state_q)
                    ST_HUNT: begin
                        if (ev.dat) begin
                            if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
                        end else begin
                            if (ones_q == ONES_MAX) state_q <= ST_START;
                            ones_q <= '0;
                        end
                    end
                    ST_START: begin
                        state_q <= ev.dat ? ST_OP : ST_HUNT;
                        cnt_q   <= '0;
                    end
                    ST_OP: begin
                        op_msb_q <= ev.dat;
                        if (cnt_q == '0) begin
                            cnt_q <= 1;
                        end else begin
                            cnt_q <= '0;
                            unique case (decode_op({op_msb_q, ev.dat}))
                                CMD_READ: begin
                                    is_read_q <= 1'b1;
                                    state_q   <= ST_ARG;
                                end
                                CMD_CLEAR: begin
                                    is_read_q <= 1'b0;
                                    state_q   <= ST_ARG;
                                end
                                default: state_q <= ST_HUNT;
                            endcase
                        end
                    end
                    ST_ARG: begin
                        arg_q <= arg_next;
                        if (cnt_q == ARG_LAST) begin
                            cnt_q <= '0;
                            if (is_read_q) begin
                                rd_stb  <= 1'b1;
                                rd_tbl  <= arg_next[ADDR_W];
                                rd_addr <= arg_next[ADDR_W-1:0];
                                state_q <= ST_TA;
                            end else begin
                                clr_stb       <= 1'b1;
                                clr_port_mode <= arg_next[ADDR_W];
                                clr_sel       <= arg_next[ADDR_W-1:0];
                                state_q       <= ST_HUNT;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_TA: begin
                        if (cnt_q == 1) begin
                            cnt_q   <= '0;
                            state_q <= ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == DAT_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_HUNT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb, clr_stb}));

    // R8
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> !clr_stb);

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);

endmodule

// File: rtl/scr_shift_out.sv
module scr_shift_out
    import scr_pkg::*;
#(
    parameter int DATA_W = SCR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  scr_edge_t         ev,
    input  logic              data_phase,
    input  logic [DATA_W-1:0] rd_data,
    output logic              ser_do,
    output logic              ser_oe
);

    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            ser_oe <= 1'b0;
        end else if (ev.fall) begin
            if (data_phase) begin
                if (!ser_oe) begin
                    sh_q   <= rd_data;
                    ser_oe <= 1'b1;
                end else begin
                    sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                end
            end else begin
                ser_oe <= 1'b0;
            end
        end
    end

    assign ser_do = sh_q[DATA_W-1];

    // R11
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        !ev.fall |=> ($stable(ser_do) && $stable(ser_oe)));

    // R5
    oe_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> $past(data_phase));

endmodule

// File: rtl/scr_slave.sv
module scr_slave
    import scr_pkg::*;
#(
    parameter int PRE_LEN     = SCR_PRE_LEN,
    parameter int ADDR_W      = SCR_ADDR_W,
    parameter int DATA_W      = SCR_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_di,
    output logic              ser_do,
    output logic              ser_oe,
    output logic              rd_stb,
    output logic              rd_tbl,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              clr_stb,
    output logic              clr_port_mode,
    output logic [ADDR_W-1:0] clr_sel
);

    scr_edge_t ev;
    logic      data_phase;

    scr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_di  (ser_di),
        .ev      (ev)
    );

    scr_frame_parser #(
        .PRE_LEN (PRE_LEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_parse (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .data_phase    (data_phase),
        .rd_stb        (rd_stb),
        .rd_tbl        (rd_tbl),
        .rd_addr       (rd_addr),
        .clr_stb       (clr_stb),
        .clr_port_mode (clr_port_mode),
        .clr_sel       (clr_sel)
    );

    scr_shift_out #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .data_phase (data_phase),
        .rd_data    (rd_data),
        .ser_do     (ser_do),
        .ser_oe     (ser_oe)
    );

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ser_oe |-> ($stable(rd_addr) && $stable(rd_tbl)));

    // R7
    no_strobe_in_data_chk: assert property (@(posedge clk) disable iff (rst)
        ser_oe |-> !(rd_stb || clr_stb));

endmodule

// File: tb/tb_scr_slave.sv
`timescale 1ns/1ps
module tb_scr_slave;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_di = 1'b1;
    logic        ser_do, ser_oe;
    logic        rd_stb, rd_tbl, clr_stb, clr_port_mode;
    logic [6:0]  rd_addr, clr_sel;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    int rd_seen = 0;
    int clr_seen = 0;
    int oe_clks = 0;
    int stab_viol = 0;
    logic       cap_tbl, cap_mode;
    logic [6:0] cap_addr, cap_sel;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model_word(input logic tbl, input logic [6:0] a);
        logic [7:0] k;
        k = {tbl, a};
        return {k ^ 8'hC3, k, ~k, k + 8'h5A};
    endfunction

    assign rd_data = model_word(rd_tbl, rd_addr);

    scr_slave dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_di(ser_di),
        .ser_do(ser_do), .ser_oe(ser_oe), .rd_stb(rd_stb), .rd_tbl(rd_tbl),
        .rd_addr(rd_addr), .rd_data(rd_data), .clr_stb(clr_stb),
        .clr_port_mode(clr_port_mode), .clr_sel(clr_sel)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (rd_stb) begin
                rd_seen  <= rd_seen + 1;
                cap_tbl  <= rd_tbl;
                cap_addr <= rd_addr;
            end
            if (clr_stb) begin
                clr_seen <= clr_seen + 1;
                cap_mode <= clr_port_mode;
                cap_sel  <= clr_sel;
            end
            if (ser_oe) oe_clks <= oe_clks + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b, output logic s_do, output logic s_oe);
        ser_di = b;
        repeat (HALF) @(posedge clk);
        #1;
        s_do = ser_do;
        s_oe = ser_oe;
        ser_clk = 1'b1;
        repeat (HALF) @(posedge clk);
        #1;
        if (ser_do !== s_do || ser_oe !== s_oe) stab_viol++;
        ser_clk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic d, o;
        for (int i = n - 1; i >= 0; i--) ser_bit(v[i], d, o);
    endtask

    task automatic header(input int pre, input logic [1:0] st, input logic [1:0] op);
        logic d, o;
        ser_bit(1'b0, d, o);
        for (int i = 0; i < pre; i++) ser_bit(1'b1, d, o);
        send({30'd0, st}, 2);
        send({30'd0, op}, 2);
    endtask

    task automatic do_read(input int pre, input logic tbl, input logic [6:0] a, input string tag);
        int r0;
        logic d, o;
        logic [31:0] got;
        int oe_hi;
        bit ta_ok;
        r0 = rd_seen;
        stab_viol = 0;
        header(pre, 2'b01, 2'b10);
        send({24'd0, tbl, a}, 8);
        check(rd_seen == r0 + 1, {tag, " R2 rd_stb count"}, rd_seen - r0, 1);
        check({cap_tbl, cap_addr} == {tbl, a}, {tag, " R2 tbl/addr"}, {cap_tbl, cap_addr}, {tbl, a});
        ta_ok = 1'b1;
        for (int i = 0; i < 2; i++) begin
            ser_bit(1'b1, d, o);
            if (o !== 1'b0) ta_ok = 1'b0;
        end
        check(ta_ok, {tag, " R5 oe low in turnaround"}, ta_ok, 1);
        oe_hi = 0;
        got = '0;
        for (int i = 31; i >= 0; i--) begin
            ser_bit(1'b1, d, o);
            got[i] = d;
            if (o === 1'b1) oe_hi++;
        end
        check(got == model_word(tbl, a), {tag, " R2 R5 read data"}, got, model_word(tbl, a));
        check(oe_hi == 32, {tag, " R6 oe high samples"}, oe_hi, 32);
        ser_bit(1'b1, d, o);
        check(o === 1'b0, {tag, " R6 oe low after data"}, o, 0);
        check(stab_viol == 0, {tag, " R11 outputs stable while serial clock high"}, stab_viol, 0);
    endtask

    task automatic do_clear(input int pre, input logic mode, input logic [6:0] sel, input string tag);
        int c0, r0, e0;
        c0 = clr_seen; r0 = rd_seen; e0 = oe_clks;
        header(pre, 2'b01, 2'b01);
        send({24'd0, mode, sel}, 8);
        send(32'hF, 4);
        check(clr_seen == c0 + 1 && rd_seen == r0, {tag, " R8 clr_stb count"}, clr_seen - c0, 1);
        check(cap_sel == sel, {tag, " R8 clr_sel"}, cap_sel, sel);
        check(cap_mode == mode, mode ? {tag, " R8 port mode"} : {tag, " R9 single counter mode"}, cap_mode, mode);
        check(oe_clks == e0, {tag, " R8 no output enable"}, oe_clks - e0, 0);
    endtask

    task automatic do_ignored(input int pre, input logic [1:0] st, input logic [1:0] op,
                              input logic [7:0] arg, input string tag);
        int c0, r0, e0;
        c0 = clr_seen; r0 = rd_seen; e0 = oe_clks;
        header(pre, st, op);
        send({24'd0, arg}, 8);
        send(32'h0, 40);
        check(clr_seen == c0 && rd_seen == r0, {tag, " no strobe"}, (clr_seen - c0) + (rd_seen - r0), 0);
        check(oe_clks == e0, {tag, " oe stays low"}, oe_clks - e0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        #1;
        check(ser_oe === 1'b0 && rd_stb === 1'b0 && clr_stb === 1'b0, "R1 reset outputs",
              {ser_oe, rd_stb, clr_stb}, 0);
        rst = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        check(rd_seen == 0 && clr_seen == 0 && oe_clks == 0, "R1 idle after reset",
              rd_seen + clr_seen + oe_clks, 0);

        do_read(32, 1'b0, 7'h00, "dir min");
        do_read(32, 1'b1, 7'h7F, "dir max");
        do_read(40, 1'b0, 7'h55, "R4 long preamble");
        do_ignored(31, 2'b01, 2'b10, 8'h2A, "R3 short preamble");
        do_ignored(32, 2'b01, 2'b00, 8'h11, "R7 opcode 00");
        do_ignored(32, 2'b01, 2'b11, 8'h22, "R7 opcode 11");
        do_read(33, 1'b1, 7'h3C, "R7 recovery read");
        do_ignored(32, 2'b00, 2'b10, 8'h33, "R10 bad start");
        do_clear(32, 1'b1, 7'h04, "dir port");
        do_clear(35, 1'b0, 7'h6B, "dir index");

        for (int n = 0; n < 28; n++) begin
            int kind, pre;
            logic [7:0] arg;
            kind = $urandom % 4;
            pre  = 32 + ($urandom % 6);
            arg  = 8'($urandom);
            case (kind)
                0, 1: do_read(pre, arg[7], arg[6:0], "rnd read");
                2:    do_clear(pre, arg[7], arg[6:0], "rnd clear");
                default: do_ignored(pre, 2'b01, (arg[0] ? 2'b11 : 2'b00), arg, "R7 rnd bad op");
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule